// File: doc/BRIEF.md
# I2C Strap-Pin Address Detector

This block is the address-recognition front end of an I2C target whose 7-bit address is chosen by a single strap pin. The pin may be tied to ground, to supply, to the SDA line or to the SCL line. The block does not latch the strap at power-up. It works the strap out again during every address byte by comparing the pin against the two bus lines and against fixed levels. All three inputs are oversampled by a fast system clock through two-flop synchronizers.

Every START or repeated START clears the classifier and the bit counter. While the master shifts in the address byte, the pin is sampled at each SCL rising edge and once more a programmable number of clock cycles after each SCL falling edge. That second sample falls inside the short window in which SDA still holds its old value. An SCL-tied pin reads low there while SDA may still be high, and this separates it from an SDA-tied pin.

At the falling SCL edge that closes the eighth bit, the classification is frozen. The upper seven received bits are then compared with the address the strap selects. On a match the block pulls SDA low for the ninth clock and reports the R/W bit. On a mismatch it leaves SDA released.

Top module: `strap_addr_detect`

## Requirements
- R1: After reset, `sda_oe` is 0, `addr_hit` is 0 and `pin_class` reads 4 (unresolved).
- R2: With the pin at ground, `pin_class` reads 0 after the address byte, and a byte carrying address 1001000 is acknowledged.
- R3: With the pin at supply, `pin_class` reads 1, and address 1001001 is acknowledged.
- R4: With the pin following SDA, `pin_class` reads 2, and address 1001010 is acknowledged.
- R5: With the pin following SCL, `pin_class` reads 3, and address 1001011 is acknowledged.
- R6: A byte whose upper seven bits differ from the strap-selected address gives no ACK and no `addr_hit`.
- R7: A pin that follows neither line and is not at a constant level classifies as 4, and no address is acknowledged.
- R8: The eighth bit (R/W, the byte's last bit) is left out of the comparison. On a match, `addr_hit` pulses for exactly one cycle with `addr_rw` equal to that bit.
- R9: The ACK (`sda_oe` = 1) is asserted while SCL is low after the eighth bit. It is held through the whole ninth SCL high phase and removed after the ninth SCL falling edge.
- R10: A STOP in the middle of the address byte abandons it. SCL clocks that follow without a new START are ignored and give no ACK.
- R11: A repeated START in the middle of the byte restarts bit counting, and the full byte that follows is judged on its own.
- R12: Classification is redone for every transaction, so changing the strap between transactions changes the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line as seen on the bus |
| sda_i | input | 1 | SDA line as seen on the bus |
| pin_i | input | 1 | Address strap pin |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low (ACK) |
| addr_hit | output | 1 | One-cycle pulse when the address matches |
| addr_rw | output | 1 | R/W bit of the matched byte, valid with `addr_hit` |
| pin_class | output | 3 | Strap result: 0 ground, 1 supply, 2 SDA, 3 SCL, 4 unresolved |

## Verification
Freezing the classification and deciding the ACK happen in the same clock cycle, at the eighth SCL falling edge. So the comparison has to see flags that already include the sample taken at the eighth rising edge. The bench provokes this for each strap, using address bytes in which that last rise sample is part of the evidence. It judges the outcome through `pin_class` and through `sda_oe` during the ninth SCL high phase. The scoreboard pairs every `addr_hit` pulse with an expected R/W value and flags any extra or missing pulse.

// File: rtl/strap_pkg.sv
package strap_pkg;
  typedef enum logic [2:0] {
    PC_GND  = 3'd0,
    PC_VDD  = 3'd1,
    PC_SDA  = 3'd2,
    PC_SCL  = 3'd3,
    PC_NONE = 3'd4
  } pin_class_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SHIFT = 2'd1,
    PH_ACK   = 2'd2
  } phase_e;

  // Strap-selected 7-bit address: fixed upper part, low two bits from the class
  function automatic logic [6:0] strap_addr(input logic [4:0] base, input pin_class_e c);
    return {base, c[1:0]};
  endfunction
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int WIDTH   = 3,
  parameter int STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= {STAGES{RST_VAL}};
    else     stg <= {stg[STAGES-2:0], din};
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/strap_bus_events.sv
module strap_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic sda,
  input  logic scl,
  output logic start_ev,
  output logic stop_ev,
  output logic scl_rise,
  output logic scl_fall
);
  logic sda_d, scl_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sda_d <= 1'b1;
      scl_d <= 1'b1;
    end else begin
      sda_d <= sda;
      scl_d <= scl;
    end
  end

  assign start_ev = scl & scl_d & sda_d & ~sda;
  assign stop_ev  = scl & scl_d & ~sda_d & sda;
  assign scl_rise = scl & ~scl_d;
  assign scl_fall = ~scl & scl_d;
endmodule

// File: rtl/strap_classifier.sv
module strap_classifier
  import strap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       sample_en,
  input  logic       pin,
  input  logic       sda,
  input  logic       scl,
  output pin_class_e cls
);
  logic follow_sda, follow_scl, split_seen, seen_hi, seen_lo;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      follow_sda <= 1'b1;
      follow_scl <= 1'b1;
      split_seen <= 1'b0;
      seen_hi    <= 1'b0;
      seen_lo    <= 1'b0;
    end else if (sample_en) begin
      if (pin != sda) follow_sda <= 1'b0;
      if (pin != scl) follow_scl <= 1'b0;
      if (sda != scl) split_seen <= 1'b1;
      if (pin)        seen_hi    <= 1'b1;
      else            seen_lo    <= 1'b1;
    end
  end

  always_comb begin
    if (follow_scl && split_seen)      cls = PC_SCL;
    else if (follow_sda && split_seen) cls = PC_SDA;
    else if (seen_lo && !seen_hi)      cls = PC_GND;
    else if (seen_hi && !seen_lo)      cls = PC_VDD;
    else                               cls = PC_NONE;
  end
endmodule

// File: rtl/strap_addr_detect.sv
module strap_addr_detect
  import strap_pkg::*;
#(
  parameter int         SAMPLE_DLY  = 10,
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_BASE   = 5'b10010
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       pin_i,
  output logic       sda_oe,
  output logic       addr_hit,
  output logic       addr_rw,
  output logic [2:0] pin_class
);
  localparam int DLY_W = $clog2(SAMPLE_DLY + 1);
  localparam logic [DLY_W-1:0] DLY_LOAD = DLY_W'(SAMPLE_DLY);
  localparam logic [3:0] BYTE_BITS = 4'd8;

  logic       s_pin, s_sda, s_scl;
  logic       start_ev, stop_ev, scl_rise, scl_fall;
  logic       fall_smp, sample_en;
  logic [DLY_W-1:0] dly_cnt;
  logic [3:0] bit_cnt;
  logic [7:0] shreg;
  phase_e     phase;
  pin_class_e cls, cls_q;
  logic       match;

  strap_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({pin_i, sda_i, scl_i}),
    .dout({s_pin, s_sda, s_scl})
  );

  strap_bus_events u_evt (
    .clk     (clk),
    .rst     (rst),
    .sda     (s_sda),
    .scl     (s_scl),
    .start_ev(start_ev),
    .stop_ev (stop_ev),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall)
  );

  // Delayed sample point after each SCL fall inside the address byte
  always_ff @(posedge clk) begin
    if (rst || start_ev || stop_ev)                          dly_cnt <= '0;
    else if (phase == PH_SHIFT && scl_fall && bit_cnt != BYTE_BITS) dly_cnt <= DLY_LOAD;
    else if (dly_cnt != '0)                                  dly_cnt <= dly_cnt - 1'b1;
  end

  assign fall_smp  = (dly_cnt == DLY_W'(1));
  assign sample_en = (phase == PH_SHIFT) && (bit_cnt != BYTE_BITS || fall_smp)
                     && ((scl_rise && bit_cnt != BYTE_BITS) || fall_smp);

  strap_classifier u_cls (
    .clk      (clk),
    .rst      (rst),
    .clear    (start_ev),
    .sample_en(sample_en),
    .pin      (s_pin),
    .sda      (s_sda),
    .scl      (s_scl),
    .cls      (cls)
  );

  assign match = (cls != PC_NONE) && (shreg[7:1] == strap_addr(ADDR_BASE, cls));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      sda_oe   <= 1'b0;
      addr_hit <= 1'b0;
      addr_rw  <= 1'b0;
      cls_q    <= PC_NONE;
    end else begin
      addr_hit <= 1'b0;
      if (start_ev) begin
        phase   <= PH_SHIFT;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_ev) begin
        phase   <= PH_IDLE;
        sda_oe  <= 1'b0;
      end else begin
        case (phase)
          PH_SHIFT: begin
            if (scl_rise && bit_cnt != BYTE_BITS) begin
              shreg   <= {shreg[6:0], s_sda};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == BYTE_BITS) begin
              cls_q <= cls;
              if (match) begin
                phase    <= PH_ACK;
                sda_oe   <= 1'b1;
                addr_hit <= 1'b1;
                addr_rw  <= shreg[0];
              end else begin
                phase <= PH_IDLE;
              end
            end
          end
          PH_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              phase  <= PH_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign pin_class = cls_q;
endmodule

// File: rtl/strap_addr_detect_chk.sv
module strap_addr_detect_chk (
  input logic       clk,
  input logic       rst,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       addr_hit,
  input logic [2:0] pin_class
);
  // R8: the match pulse lasts one cycle
  assert_hit_single_R8: assert property (@(posedge clk) disable iff (rst)
    addr_hit |=> !addr_hit);

  // R8: a match pulse always comes with the ACK drive
  assert_hit_with_ack_R8: assert property (@(posedge clk) disable iff (rst)
    addr_hit |-> sda_oe);

  // R7: no match while the strap is unresolved
  assert_hit_resolved_R7: assert property (@(posedge clk) disable iff (rst)
    addr_hit |-> (pin_class != 3'd4));

  // R9: ACK drive changes only while SCL is low
  assert_oe_stable_high_R9: assert property (@(posedge clk) disable iff (rst)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe));

  assert_oe_rise_low_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_i);

  assert_oe_fall_low_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_oe) |-> !scl_i);
endmodule

bind strap_addr_detect strap_addr_detect_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .scl_i    (scl_i),
  .sda_oe   (sda_oe),
  .addr_hit (addr_hit),
  .pin_class(pin_class)
);

// File: tb/test_strap_addr_detect.sv
module test_strap_addr_detect;
  localparam int Q = 50;  // quarter SCL period in clocks (200 ns)

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  int   tie = 0;        // 0 gnd, 1 vdd, 2 sda, 3 scl, 4 inverted sda
  logic sda_line, pin_line;
  logic sda_oe, addr_hit, addr_rw;
  logic [2:0] pin_class;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic exp_q[$];

  always #2 clk = ~clk;  // 250 MHz

  assign sda_line = m_sda & ~sda_oe;
  always_comb begin
    case (tie)
      0:       pin_line = 1'b0;
      1:       pin_line = 1'b1;
      2:       pin_line = sda_line;
      3:       pin_line = m_scl;
      default: pin_line = ~sda_line;
    endcase
  end

  strap_addr_detect i_strap_addr_detect (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .pin_i(pin_line),
    .sda_oe(sda_oe), .addr_hit(addr_hit), .addr_rw(addr_rw), .pin_class(pin_class)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pair each match pulse with the queued expectation
  always @(negedge clk) begin
    if (!rst && addr_hit) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R8 unexpected addr_hit actual=1 expected=0");
      end else begin
        logic e;
        e = exp_q.pop_front();
        if (addr_rw !== e) begin
          n_fail++;
          $display("FAIL R8 addr_rw actual=%0b expected=%0b", addr_rw, e);
        end
      end
    end
  end

  task automatic wq(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    wq(Q); m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    wq(Q); m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(Q);
  endtask

  task automatic send_bit(input logic b);
    wq(Q); m_sda = b; wq(Q); m_scl = 1'b1; wq(2 * Q); m_scl = 1'b0;
  endtask

  task automatic ack_phase(input string req, input logic exp_ack, input logic [2:0] exp_cls);
    wq(Q); m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
    @(negedge clk);
    chk({req, " ack during 9th clock"}, {7'd0, sda_oe}, {7'd0, exp_ack});
    chk({req, " pin_class"}, {5'd0, pin_class}, {5'd0, exp_cls});
    wq(Q); m_scl = 1'b0; wq(Q / 2);
    @(negedge clk);
    chk("R9 ack released after 9th fall", {7'd0, sda_oe}, 8'd0);
  endtask

  function automatic logic [6:0] strap_of(input int t);
    return {5'b10010, 2'(t)};
  endfunction

  task automatic xfer(input string req, input int t, input logic [6:0] a, input logic rw,
                      input logic [2:0] exp_cls);
    logic [7:0] byte_v;
    logic hit;
    tie = t;
    byte_v = {a, rw};
    hit = (exp_cls != 3'd4) && (a == strap_of(int'(exp_cls)));
    if (hit) exp_q.push_back(rw);
    bus_start();
    for (int i = 7; i >= 0; i--) send_bit(byte_v[i]);
    ack_phase(req, hit, exp_cls);
    bus_stop();
  endtask

  initial begin
    wq(10);
    @(negedge clk);
    chk("R1 reset sda_oe", {7'd0, sda_oe}, 8'd0);
    chk("R1 reset addr_hit", {7'd0, addr_hit}, 8'd0);
    chk("R1 reset pin_class", {5'd0, pin_class}, 8'd4);
    rst = 1'b0;
    wq(20);

    xfer("R2 gnd write", 0, 7'b1001000, 1'b0, 3'd0);
    xfer("R3 vdd read", 1, 7'b1001001, 1'b1, 3'd1);
    xfer("R4 sda write", 2, 7'b1001010, 1'b0, 3'd2);
    xfer("R5 scl read", 3, 7'b1001011, 1'b1, 3'd3);
    xfer("R5 scl write", 3, 7'b1001011, 1'b0, 3'd3);
    xfer("R6 gnd strap, scl address", 0, 7'b1001011, 1'b0, 3'd0);
    xfer("R6 scl strap, gnd address", 3, 7'b1001000, 1'b1, 3'd3);
    xfer("R6 sda strap, vdd address", 2, 7'b1001001, 1'b0, 3'd2);
    xfer("R7 inverted pin", 4, 7'b1001000, 1'b0, 3'd4);
    xfer("R7 inverted pin other addr", 4, 7'b1001011, 1'b1, 3'd4);
    xfer("R8 rw ignored, vdd write", 1, 7'b1001001, 1'b0, 3'd1);
    xfer("R12 back to gnd read", 0, 7'b1001000, 1'b1, 3'd0);

    // R10: STOP after four bits, then the rest of a valid byte without START
    tie = 0;
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
    bus_stop();
    m_scl = 1'b1;
    wq(Q); m_scl = 1'b0;
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
    wq(Q); m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
    @(negedge clk);
    chk("R10 no ack after abandoned byte", {7'd0, sda_oe}, 8'd0);
    wq(Q); m_scl = 1'b0;
    bus_stop();

    // R11: repeated START after three bits, then a full valid byte
    tie = 3;
    bus_start();
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    exp_q.push_back(1'b0);
    bus_start();
    for (int i = 7; i >= 0; i--) send_bit(8'b10010110 >> i);
    ack_phase("R11 restart then scl address", 1'b1, 3'd3);
    bus_stop();

    wq(Q);
    chk("R8 all expected pulses seen", 8'(exp_q.size()), 8'd0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule